// File: doc/BRIEF.md
# PSK Frame Formatter

This block turns a host byte stream into the ordered byte sequence of a transmit frame for a phase-shift-keyed power line modem. A one-cycle `start` request, accepted only while the block is idle, begins a frame. The block emits the following bytes in order:

- a run of `0xAA` synchronisation bytes, whose count is programmable;
- a fixed start-of-frame word;
- a byte naming the payload modulation;
- the payload, taken from the host.

The first payload byte is a count. Exactly that many further bytes follow it, and then the frame closes with a `done` pulse.

Every byte that leaves the block carries a 3-bit modulation tag, so a downstream symbol mapper knows when to change constellation. All header bytes are tagged for plain binary PSK. The count byte and the bytes that follow it are tagged with the mode chosen for this frame. Both byte streams use valid/ready handshakes, and the output is a registered stage.

Top module: `psk_frame_fmt`

## Requirements
- R1: After reset, `out_valid`, `in_ready`, `busy`, `done` and `err` are all low.
- R2: A frame opens with N bytes of value 0xAA, each tagged 0. N is `pre_len` clamped to the range 2..5, so 0 or 1 gives 2 and 6 or 7 gives 5.
- R3: The two bytes of the 16-bit start-of-frame word follow the synchronisation bytes, high byte first, each tagged 0.
- R4: Next comes one byte equal to the mode code, zero-extended and tagged 0. The codes are: 0 binary PSK, 1 quadrature PSK, 2 eight-phase PSK, 3 coded binary, 4 coded quadrature, 5 coded binary with peak-noise avoidance.
- R5: The first host byte, L, is forwarded after the mode byte. Exactly L further host bytes are then forwarded in order, and all L+1 of these bytes are tagged with the frame's mode code. When L is 0, the frame ends after the count byte.
- R6: A start with mode code 6 or 7 produces a one-cycle `err` pulse in the cycle after the request. No byte is emitted and `busy` stays low.
- R7: `done` is a one-cycle pulse in the cycle after the final byte is handed over at the output. `busy` falls in that same cycle.
- R8: `pre_len`, `mode_sel` and `start` are ignored while `busy` is high. This includes a start that arrives in the same cycle as the final output handshake.
- R9: While `out_valid` is high and `out_ready` is low, the output byte and tag hold steady. No byte is lost or repeated. `in_ready` is high only during the payload phase of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, sampled while idle |
| pre_len | input | 3 | Synchronisation byte count request |
| mode_sel | input | 3 | Payload modulation code |
| in_data | input | 8 | Host payload byte |
| in_valid | input | 1 | Host byte available |
| in_ready | output | 1 | Block accepts a host byte |
| out_data | output | 8 | Frame byte |
| out_tag | output | 3 | Modulation tag for `out_data` |
| out_valid | output | 1 | Frame byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame completed pulse |
| err | output | 1 | Rejected mode pulse |

## Verification
Two events can fall in the same cycle: the handover of a frame's last byte, and a fresh start request. The bench raises `start` in exactly the cycle where it sees `out_valid` and drives `out_ready` for the final byte. It then judges that `done` pulses once, that `busy` drops, and that the output stays silent for the following cycles. Random stalls on both handshakes also place payload acceptance in the same cycle as output backpressure. Those cases are judged by comparing every emitted byte and tag, in order, with a list the bench builds from the requirements.

// File: rtl/psk_fmt_pkg.sv
`timescale 1ns/1ps
package psk_fmt_pkg;
  localparam int TAG_W = 3;
  localparam logic [TAG_W-1:0] TAG_BPSK = 3'd0;
  localparam logic [TAG_W-1:0] TAG_LAST = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_UW, S_MODE, S_LEN, S_BODY, S_DRAIN
  } fmt_state_e;
endpackage

// File: rtl/psk_fmt_outq.sv
`timescale 1ns/1ps
module psk_fmt_outq #(
  parameter int DW = 8,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nxt_valid,
  input  logic [DW-1:0] nxt_data,
  input  logic [TW-1:0] nxt_tag,
  input  logic          out_ready,
  output logic          adv,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [TW-1:0] out_tag
);
  assign adv = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
    end else if (adv) begin
      out_valid <= nxt_valid;
      if (nxt_valid) begin
        out_data <= nxt_data;
        out_tag  <= nxt_tag;
      end
    end
  end

  // R9: a stalled byte must not change
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));
endmodule

// File: rtl/psk_fmt_ctrl.sv
`timescale 1ns/1ps
module psk_fmt_ctrl
  import psk_fmt_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          UW_W    = 16,
  parameter logic [UW_W-1:0] UW_WORD = 16'hE1B4,
  parameter int          PRE_MIN = 2,
  parameter int          PRE_MAX = 5,
  parameter int          PL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PL_W-1:0]  pre_len,
  input  logic [TAG_W-1:0] mode_sel,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             adv,
  input  logic             out_fire,
  output logic             nxt_valid,
  output logic [DW-1:0]    nxt_data,
  output logic [TAG_W-1:0] nxt_tag,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int UW_NB = UW_W / DW;
  localparam int UW_CW = (UW_NB > 1) ? $clog2(UW_NB) : 1;
  localparam logic [PL_W-1:0] P_MIN = PL_W'(PRE_MIN);
  localparam logic [PL_W-1:0] P_MAX = PL_W'(PRE_MAX);
  localparam logic [UW_CW-1:0] UW_END = UW_CW'(UW_NB - 1);

  fmt_state_e       state;
  logic [PL_W-1:0]  pre_q, pre_cnt;
  logic [UW_CW-1:0] uw_cnt;
  logic [UW_W-1:0]  uw_sh;
  logic [TAG_W-1:0] mode_q;
  logic [DW-1:0]    body_cnt;
  logic             take;

  function automatic logic [PL_W-1:0] clamp_len(input logic [PL_W-1:0] v);
    if (v < P_MIN)      return P_MIN;
    else if (v > P_MAX) return P_MAX;
    else                return v;
  endfunction

  always_comb begin
    nxt_valid = 1'b0;
    nxt_data  = '0;
    nxt_tag   = TAG_BPSK;
    unique case (state)
      S_PRE:  begin nxt_valid = 1'b1; nxt_data = 8'hAA; end
      S_UW:   begin nxt_valid = 1'b1; nxt_data = uw_sh[UW_W-1 -: DW]; end
      S_MODE: begin nxt_valid = 1'b1; nxt_data = DW'(mode_q); end
      S_LEN, S_BODY: begin
        nxt_valid = in_valid;
        nxt_data  = in_data;
        nxt_tag   = mode_q;
      end
      default: ;
    endcase
  end

  assign take     = nxt_valid && adv;
  assign in_ready = ((state == S_LEN) || (state == S_BODY)) && adv;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pre_q    <= P_MIN;
      pre_cnt  <= '0;
      uw_cnt   <= '0;
      uw_sh    <= '0;
      mode_q   <= TAG_BPSK;
      body_cnt <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (mode_sel > TAG_LAST) err <= 1'b1;
          else begin
            mode_q  <= mode_sel;
            pre_q   <= clamp_len(pre_len);
            pre_cnt <= '0;
            uw_cnt  <= '0;
            uw_sh   <= UW_WORD;
            state   <= S_PRE;
          end
        end
        S_PRE: if (take) begin
          if (pre_cnt == pre_q - PL_W'(1)) state <= S_UW;
          else pre_cnt <= pre_cnt + PL_W'(1);
        end
        S_UW: if (take) begin
          uw_sh <= uw_sh << DW;
          if (uw_cnt == UW_END) state <= S_MODE;
          else uw_cnt <= uw_cnt + UW_CW'(1);
        end
        S_MODE: if (take) state <= S_LEN;
        S_LEN: if (take) begin
          body_cnt <= in_data;
          state    <= (in_data == '0) ? S_DRAIN : S_BODY;
        end
        S_BODY: if (take) begin
          body_cnt <= body_cnt - DW'(1);
          if (body_cnt == DW'(1)) state <= S_DRAIN;
        end
        S_DRAIN: if (out_fire) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: the body phase never runs with nothing left to forward
  assert_body_left_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_BODY) |-> (body_cnt != '0));
  // R2: latched preamble count stays within its legal range during a frame
  assert_pre_range_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pre_q >= P_MIN && pre_q <= P_MAX));
endmodule

// File: rtl/psk_frame_fmt.sv
`timescale 1ns/1ps
module psk_frame_fmt
  import psk_fmt_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          UW_W    = 16,
  parameter logic [UW_W-1:0] UW_WORD = 16'hE1B4,
  parameter int          PRE_MIN = 2,
  parameter int          PRE_MAX = 5,
  parameter int          PL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PL_W-1:0]  pre_len,
  input  logic [TAG_W-1:0] mode_sel,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [DW-1:0]    out_data,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             done,
  output logic             err
);
  logic             adv, nxt_valid;
  logic [DW-1:0]    nxt_data;
  logic [TAG_W-1:0] nxt_tag;
  logic             out_fire;

  assign out_fire = out_valid && out_ready;

  psk_fmt_ctrl #(
    .DW(DW), .UW_W(UW_W), .UW_WORD(UW_WORD),
    .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX), .PL_W(PL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pre_len(pre_len),
    .mode_sel(mode_sel), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .adv(adv), .out_fire(out_fire),
    .nxt_valid(nxt_valid), .nxt_data(nxt_data), .nxt_tag(nxt_tag),
    .busy(busy), .done(done), .err(err)
  );

  psk_fmt_outq #(.DW(DW), .TW(TAG_W)) u_outq (
    .clk(clk), .rst(rst), .nxt_valid(nxt_valid), .nxt_data(nxt_data),
    .nxt_tag(nxt_tag), .out_ready(out_ready), .adv(adv),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
  );

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !out_valid));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !out_valid));
  assert_tag_legal_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_tag <= TAG_LAST));
  assert_inready_busy_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);
endmodule

// File: tb/tb_psk_frame_fmt.sv
`timescale 1ns/1ps
module tb_psk_frame_fmt;
  localparam logic [15:0] UW = 16'hE1B4;

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] pre_len = 3'd0, mode_sel = 3'd0;
  logic [7:0] in_data = 8'd0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic       in_ready, out_valid, busy, done, err;
  logic [7:0] out_data;
  logic [2:0] out_tag;

  int nchk = 0, nbad = 0;
  int exp_b[0:300];
  int exp_t[0:300];
  int pay[0:256];

  always #4 clk = ~clk;

  psk_frame_fmt #(.UW_WORD(UW)) dut (
    .clk(clk), .rst(rst), .start(start), .pre_len(pre_len),
    .mode_sel(mode_sel), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_tag(out_tag),
    .out_valid(out_valid), .out_ready(out_ready), .busy(busy),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int clamp_n(input int p);
    if (p < 2) return 2;
    if (p > 5) return 5;
    return p;
  endfunction

  task automatic run_frame(input int plen, input int mode, input int len,
                           input int rdy_pct, input int vld_pct);
    int n, total, idx_in, idx_out, cyc;
    bit last_prev, fo, fi;
    string rq;
    n = clamp_n(plen);
    total = 0;
    for (int i = 0; i < n; i++) begin exp_b[total] = 8'hAA; exp_t[total] = 0; total++; end
    exp_b[total] = UW[15:8]; exp_t[total] = 0; total++;
    exp_b[total] = UW[7:0];  exp_t[total] = 0; total++;
    exp_b[total] = mode;     exp_t[total] = 0; total++;
    pay[0] = len;
    for (int i = 1; i <= len; i++) pay[i] = $urandom % 256;
    for (int i = 0; i <= len; i++) begin exp_b[total] = pay[i]; exp_t[total] = mode; total++; end

    @(negedge clk);
    start = 1'b1; pre_len = 3'(plen); mode_sel = 3'(mode);
    @(negedge clk);
    start = 1'b0;
    pre_len = 3'($urandom % 8); mode_sel = 3'($urandom % 8);   // R8 disturbance
    idx_in = 0; idx_out = 0; last_prev = 1'b0; cyc = 0;
    forever begin
      chk(done == last_prev, "R7 done timing", done, last_prev);
      if (last_prev) begin
        chk(!busy, "R7 busy falls", busy, 0);
        break;
      end
      in_valid = (idx_in <= len) && (($urandom % 100) < vld_pct);
      in_data  = (idx_in <= len) ? 8'(pay[idx_in]) : 8'($urandom);
      out_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (idx_out == total - 1) start = out_valid && out_ready;   // R8 collision
      else start = (($urandom % 8) == 0);
      if ((idx_out % 5) == 0) begin pre_len = 3'($urandom); mode_sel = 3'($urandom); end
      fo = out_valid && out_ready;
      fi = in_valid && in_ready;
      last_prev = 1'b0;
      if (fo) begin
        if (idx_out >= total) chk(0, "R5 extra byte", out_data, -1);
        else begin
          if (idx_out < n) rq = "R2 preamble";
          else if (idx_out < n + 2) rq = "R3 start word";
          else if (idx_out == n + 2) rq = "R4 mode byte";
          else rq = "R5 payload";
          chk(out_data == 8'(exp_b[idx_out]), rq, out_data, exp_b[idx_out]);
          chk(out_tag == 3'(exp_t[idx_out]), {rq, " tag"}, out_tag, exp_t[idx_out]);
        end
        idx_out++;
        last_prev = (idx_out == total);
      end
      if (fi) idx_in++;
      @(negedge clk);
      cyc++;
      if (cyc > 8000) begin chk(0, "R9 frame stalled", idx_out, total); break; end
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid && !busy, "R8 start ignored while busy", {out_valid, busy}, 0);
    end
  endtask

  task automatic bad_mode(input int mode);
    @(negedge clk);
    start = 1'b1; mode_sel = 3'(mode); pre_len = 3'd3;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R6 err pulse", err, 1);
    chk(!busy, "R6 no busy", busy, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!err && !busy && !out_valid, "R6 nothing sent", {err, busy, out_valid}, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !in_ready && !busy && !done && !err, "R1 reset state",
        {out_valid, in_ready, busy, done, err}, 0);
    run_frame(2, 0, 0, 100, 100);
    run_frame(5, 5, 3, 100, 100);
    run_frame(1, 2, 4, 50, 70);
    run_frame(0, 1, 2, 60, 60);
    run_frame(7, 3, 1, 40, 90);
    run_frame(6, 4, 255, 80, 80);
    bad_mode(6);
    bad_mode(7);
    for (int k = 0; k < 20; k++)
      run_frame($urandom % 8, $urandom % 6, $urandom % 40, 30 + $urandom % 71, 30 + $urandom % 71);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule